// File: doc/BRIEF.md
# Master-Clock to Frame-Rate Ratio Detector

This block finds the ratio between the master clock and the audio sample rate without any configuration. It counts the master clock cycles between consecutive rising edges of the left/right frame clock. It then matches that count against a fixed set of oversampling ratios. The ratio code it reports tells the digital filter and noise-shaper control which rate to run at.

A measured period belongs to a ratio when it lies within a fixed tolerance of that ratio's nominal count. A period that fits no ratio is flagged as a mismatch and classified as the highest ratio. The reported code changes only after two back-to-back periods agree, so a single disturbed frame cannot move it. Only rising frame-clock edges are used, so the high time of the frame clock and its phase against the master clock have no effect.

Top module: `clk_ratio_detect`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `ratio_code` is 6 (1152fs), `ratio_valid` is 0 and `ratio_mismatch` is 0.
- R2: A period is the number of master clock cycles from one sampled rising edge of `frame_clk` to the next. The stretch from reset to the first rising edge is not measured.
- R3: Ratio codes 0 to 6 mean 128, 192, 256, 384, 512, 768 and 1152 master clocks per frame. A period matches a code when it is within ±32 of that count, with both ends included. For example, 96 matches code 0 and 95 matches nothing.
- R4: Where two windows meet (160, 224), the lower code wins.
- R5: A period that fits no window is classified as code 6. It sets `ratio_mismatch` to 1 until the next measured period, and that next period sets the flag again from its own result.
- R6: The period counter stops at 2047 and does not wrap. A period of 2047 or more is therefore a mismatch.
- R7: `ratio_code` takes a new class only when two consecutive measured periods give that same class. `ratio_valid` rises with the first such update and stays high until reset.
- R8: `ratio_code`, `ratio_valid` and `ratio_mismatch` change only in the cycle after a rising edge of `frame_clk` that ends a measured period.
- R9: The high time of `frame_clk` does not affect the result. Periods of the same length give the same class whatever their duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk | input | 1 | Left/right frame clock, synchronous to `clk` |
| ratio_code | output | 3 | Confirmed ratio code (0..6) |
| ratio_valid | output | 1 | A ratio has been confirmed since reset |
| ratio_mismatch | output | 1 | The last measured period fit no window |

## Verification
The assertions assume that `frame_clk` is already synchronous to `clk`, so it is sampled directly with no synchronizer. They also assume reset is held for at least one edge before checks start. The bench changes `frame_clk` only on falling master-clock edges, so each rising frame edge is seen at exactly one rising `clk` edge. Every generated period is at least two cycles long, so each rising frame edge is separate from the next. Periods are chosen at window edges, in the overlap points, past the counter limit, and with high times from one cycle up to one cycle short of the period.

// File: rtl/crd_pkg.sv
// Package: shared constants and the nominal ratio table for the ratio detector.
// Assumes seven supported ratios, listed in rising order of code.
package crd_pkg;

    localparam int N_RATIO  = 7;
    localparam int CODE_W   = $clog2(N_RATIO);
    localparam int FALLBACK = N_RATIO - 1;

    // Nominal master clocks per frame for a ratio code.
    function automatic int ratio_nominal(input int idx);
        case (idx)
            0:       return 128;
            1:       return 192;
            2:       return 256;
            3:       return 384;
            4:       return 512;
            5:       return 768;
            default: return 1152;
        endcase
    endfunction

endpackage

// File: rtl/crd_period_counter.sv
// Module: crd_period_counter
// Finds rising edges of the frame clock in the master clock domain and
// counts the master cycles between them. The counter stops at its maximum.
// Assumes frame_clk is synchronous to clk (no synchronizer is used).
module crd_period_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_clk,
    output logic [CNT_W-1:0] meas_cnt,
    output logic             meas_stb
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             frame_q;
    logic             primed;
    logic [CNT_W-1:0] cnt;
    logic             rise;

    assign rise = frame_clk && !frame_q;

    // Keeps the previous frame clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= 1'b0;
        else        frame_q <= frame_clk;
    end

    // Counts cycles since the last rising edge and stops at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (rise)           cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Marks that one edge has been seen, so the next edge closes a full period.
    always_ff @(posedge clk) begin
        if (!rst_n)    primed <= 1'b0;
        else if (rise) primed <= 1'b1;
    end

    // Captures the finished period and pulses the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_cnt <= '0;
            meas_stb <= 1'b0;
        end else begin
            meas_stb <= rise && primed;
            if (rise) meas_cnt <= cnt;
        end
    end

    AST_CNT_HOLDS_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !rise) |=> (cnt == CNT_MAX)); // R6
    AST_CNT_NEVER_ZERO_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (cnt != '0)); // R2
    AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        meas_stb |=> !meas_stb); // R2

endmodule

// File: rtl/crd_ratio_classifier.sv
// Module: crd_ratio_classifier
// Matches a measured period against the tolerance window of every supported
// ratio. The lowest matching code wins. A count at the counter limit, or one
// that fits no window, becomes the fallback code with miss set.
// Assumes windows are checked only while meas_stb is high downstream.
module crd_ratio_classifier
    import crd_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  meas_cnt,
    output logic [CODE_W-1:0] cls,
    output logic              miss
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [N_RATIO-1:0] hits;
    logic               saturated;

    assign saturated = (meas_cnt == CNT_MAX);

    // One window comparator per supported ratio.
    for (genvar i = 0; i < N_RATIO; i++) begin : g_win
        localparam int LO = ratio_nominal(i) - TOL;
        localparam int HI = ratio_nominal(i) + TOL;
        assign hits[i] = !saturated
                      && (int'(meas_cnt) >= LO)
                      && (int'(meas_cnt) <= HI);
    end

    // Picks the lowest matching code, or falls back when none matches.
    always_comb begin
        cls = CODE_W'(FALLBACK);
        for (int i = N_RATIO - 1; i >= 0; i--) begin
            if (hits[i]) cls = CODE_W'(i);
        end
    end

    assign miss = (hits == '0);

    AST_MISS_GIVES_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (cls == CODE_W'(FALLBACK))); // R5
    AST_SAT_IS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        saturated |-> miss); // R6
    AST_AT_MOST_TWO_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hits) <= 2); // R4

endmodule

// File: rtl/crd_confirm.sv
// Module: crd_confirm
// Holds the reported ratio. It takes a new class only when two consecutive
// measured periods agree, and it registers the mismatch flag once per period.
// Assumes stb is a single-cycle pulse qualifying cls and miss.
module crd_confirm
    import crd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [CODE_W-1:0] cls,
    input  logic              miss,
    output logic [CODE_W-1:0] ratio_code,
    output logic              ratio_valid,
    output logic              ratio_mismatch
);
    logic [CODE_W-1:0] prev_cls;
    logic              prev_ok;
    logic              agree;

    assign agree = stb && prev_ok && (prev_cls == cls);

    // Remembers the class of the last measured period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cls <= '0;
            prev_ok  <= 1'b0;
        end else if (stb) begin
            prev_cls <= cls;
            prev_ok  <= 1'b1;
        end
    end

    // Updates the reported code and valid flag when two periods agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_code  <= CODE_W'(FALLBACK);
            ratio_valid <= 1'b0;
        end else if (agree) begin
            ratio_code  <= cls;
            ratio_valid <= 1'b1;
        end
    end

    // Registers the mismatch result of each measured period.
    always_ff @(posedge clk) begin
        if (!rst_n)   ratio_mismatch <= 1'b0;
        else if (stb) ratio_mismatch <= miss;
    end

    AST_CODE_HOLDS_WITHOUT_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(ratio_code) && $stable(ratio_mismatch)); // R8
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_valid |=> ratio_valid); // R7
    AST_VALID_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ratio_valid) |-> $past(stb)); // R7
    AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_code <= CODE_W'(FALLBACK)); // R3

endmodule

// File: rtl/clk_ratio_detect.sv
// Module: clk_ratio_detect (top)
// Reports the ratio between master clock and sample rate from the frame clock
// alone. The chain is edge detect and period count, then window match, then
// two-period confirmation.
// Assumes frame_clk is synchronous to clk; reset is synchronous, active low.
module clk_ratio_detect
    import crd_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_clk,
    output logic [CODE_W-1:0] ratio_code,
    output logic              ratio_valid,
    output logic              ratio_mismatch
);
    logic [CNT_W-1:0]  meas_cnt;
    logic              meas_stb;
    logic [CODE_W-1:0] cls;
    logic              miss;

    crd_period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_clk(frame_clk),
        .meas_cnt (meas_cnt),
        .meas_stb (meas_stb)
    );

    crd_ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
        .clk     (clk),
        .rst_n   (rst_n),
        .meas_cnt(meas_cnt),
        .cls     (cls),
        .miss    (miss)
    );

    crd_confirm u_conf (
        .clk           (clk),
        .rst_n         (rst_n),
        .stb           (meas_stb),
        .cls           (cls),
        .miss          (miss),
        .ratio_code    (ratio_code),
        .ratio_valid   (ratio_valid),
        .ratio_mismatch(ratio_mismatch)
    );

    AST_MISMATCH_ONLY_AFTER_MEASURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ratio_mismatch) |-> $past(meas_stb)); // R5

endmodule

// File: tb/clk_ratio_detect_bench.sv
module clk_ratio_detect_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic [2:0] ratio_code;
    logic       ratio_valid;
    logic       ratio_mismatch;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #10 clk = ~clk; // 50 MHz

    clk_ratio_detect u_clk_ratio_detect (
        .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
        .ratio_code(ratio_code), .ratio_valid(ratio_valid),
        .ratio_mismatch(ratio_mismatch)
    );

    // Behavioural reference model, written from the requirements.
    int  m_run, m_code, m_last;
    bit  m_prev_frame, m_seen, m_valid, m_mis, m_have_last;
    int  pend_q[$];

    function automatic int classify(input int p);
        int nom[7] = '{128, 192, 256, 384, 512, 768, 1152};
        if (p >= 2047) return -1;
        foreach (nom[i]) if (p >= nom[i] - 32 && p <= nom[i] + 32) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_run = 0; m_code = 6; m_last = 0; m_prev_frame = 0; m_seen = 0;
            m_valid = 0; m_mis = 0; m_have_last = 0; pend_q.delete();
        end else begin
            if (pend_q.size() > 0) begin
                int c;
                c = pend_q.pop_front();
                m_mis = (c < 0);
                if (c < 0) c = 6;
                if (m_have_last && m_last == c) begin m_code = c; m_valid = 1; end
                m_last = c; m_have_last = 1;
            end
            if (frame_clk && !m_prev_frame) begin
                if (m_seen) pend_q.push_back(classify(m_run));
                m_run = 1; m_seen = 1;
            end else if (m_run < 2047) m_run++;
            m_prev_frame = frame_clk;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Every-cycle comparison against the model (R8 timing, R7 confirm, R5 flag).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8", "ratio_code vs model", ratio_code, m_code);
            check("R7", "ratio_valid vs model", ratio_valid, m_valid);
            check("R5", "ratio_mismatch vs model", ratio_mismatch, m_mis);
        end
    end

    task automatic run_periods(input int p, input int hi, input int n);
        for (int k = 0; k < n; k++)
            for (int c = 0; c < p; c++) begin
                @(negedge clk);
                frame_clk = (c < hi);
            end
    endtask

    task automatic expect_out(input string req, input int code, input int valid, input int mis);
        @(negedge clk);
        check(req, "ratio_code", ratio_code, code);
        check(req, "ratio_valid", ratio_valid, valid);
        check(req, "ratio_mismatch", ratio_mismatch, mis);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1", "ratio_code in reset", ratio_code, 6);
        check("R1", "ratio_valid in reset", ratio_valid, 0);
        rst_n = 1'b1;
        expect_out("R1", 6, 0, 0);
        run_periods(256, 128, 4);  expect_out("R2", 2, 1, 0);
        run_periods(96, 48, 4);    expect_out("R3", 0, 1, 0);
        run_periods(95, 40, 4);    expect_out("R3", 6, 1, 1);
        run_periods(160, 80, 4);   expect_out("R4", 0, 1, 0);
        run_periods(224, 100, 4);  expect_out("R4", 1, 1, 0);
        run_periods(1184, 600, 4); expect_out("R3", 6, 1, 0);
        run_periods(800, 400, 4);  expect_out("R3", 5, 1, 0);
        run_periods(512, 256, 4);  expect_out("R3", 4, 1, 0);
        // R7: alternating classes never confirm, code holds at 4
        for (int k = 0; k < 3; k++) begin
            run_periods(256, 128, 1);
            run_periods(384, 192, 1);
        end
        expect_out("R7", 4, 1, 0);
        run_periods(256, 128, 4);  expect_out("R7", 2, 1, 0);
        run_periods(300, 150, 4);  expect_out("R5", 6, 1, 1);
        run_periods(256, 128, 4);  expect_out("R5", 2, 1, 0);
        // R6: 2304 would wrap to 256 without saturation
        run_periods(2304, 5, 3);   expect_out("R6", 6, 1, 1);
        run_periods(384, 1, 4);    expect_out("R9", 3, 1, 0);
        run_periods(384, 383, 2);
        run_periods(384, 7, 2);    expect_out("R9", 3, 1, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule